// File: doc/BRIEF.md
# Time-Tag Gate with Edge and Level Windows

This block sits in a stream of time tags. Each tag carries a channel number and a timestamp counted in fine time units. The block forwards a tag or drops it, depending on a gate. Tags enter and leave through valid/ready handshakes. A free-running time count, `nowTime`, comes from outside the block and uses the same units as the timestamps.

In edge mode, a tag on the trigger channel opens a window. Channel numbers start at zero, so the eighth input is channel 7. The window has a programmable width and is shifted from the trigger timestamp by a signed offset, so it may begin before the trigger. To decide correctly on tags that came before their trigger, every tag is held in a bounded FIFO. A tag stays there until `nowTime` reaches its timestamp plus the largest negative offset the block allows. Only then is the tag compared with the most recent window. A later trigger replaces the window.

In level mode, the level input stands for the ninth input. It is sampled when a tag is accepted, and the tag passes only if that sample was high. A third mode forwards every tag.

Top module: `tagGate`

## Requirements
- R1: After reset, `outValid` is 0 and `inReady` is 1.
- R2: A tag with timestamp ts is not released before `nowTime >= ts + HOLD`, where HOLD = 2^(OFF_W-1) (128 by default). A released tag appears on `outValid` one cycle after its release. Forwarded tags leave in the order they arrived.
- R3: With `gateMode` set to 0 or 3 (off), every tag is forwarded.
- R4: With `gateMode` = 1 (edge), a tag on channel TRIG_CH (default 7) with timestamp T defines the window [T+offset, T+offset+width). The start is inclusive and the end is exclusive. A tag on any other channel is forwarded only if its timestamp lies inside the window. Before the first trigger, no such tag passes.
- R5: A negative `gateOffset` (two's complement, OFF_W bits) places the window before its trigger. Tags that entered before the trigger are still forwarded when they fall inside that window.
- R6: A new trigger restarts the window. A tag whose timestamp is at or after the new window's start is judged against the new window only.
- R7: In edge mode, tags on the trigger channel are forwarded when `passTrig` = 1 and dropped when `passTrig` = 0.
- R8: With `gateMode` = 2 (level), `levelIn` is sampled in the cycle a tag is accepted. The tag is forwarded if the sample was 1 and dropped if it was 0.
- R9: The mode is applied to each tag once, at its release from the FIFO. A mode change therefore affects only tags released after the change.
- R10: While `outValid` is high and `outReady` is low, the output tag holds steady. With DEPTH tags stored, `inReady` is 0 and further input is not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| nowTime | input | TS_W | Current time in timestamp units |
| gateMode | input | 2 | 0/3 off, 1 edge gate, 2 level gate |
| gateOffset | input | OFF_W | Signed window offset from the trigger |
| gateWidth | input | WID_W | Window length |
| passTrig | input | 1 | Forward trigger-channel tags in edge mode |
| levelIn | input | 1 | Level-gate control |
| inValid | input | 1 | Input tag valid |
| inReady | output | 1 | Input can accept a tag |
| inChan | input | CH_W | Input tag channel |
| inTs | input | TS_W | Input tag timestamp |
| outValid | output | 1 | Output tag valid |
| outReady | input | 1 | Downstream accepts the output tag |
| outChan | output | CH_W | Output tag channel |
| outTs | output | TS_W | Output tag timestamp |

## Verification
The assertions assume the following about the inputs:
- Input timestamps never decrease.
- `nowTime` never decreases.
- Only one trigger waits unapplied at a time. A second trigger enters only when no tag between the two triggers is still waiting for a decision.

The stimulus keeps to these rules. It resets between scenarios and keeps `nowTime` at zero while it loads tags in timestamp order, then moves `nowTime` forward in one step. Where it sends back-to-back triggers, no tag is placed between them.

// File: rtl/tgate_pkg.sv
package tgate_pkg;
  typedef enum logic [1:0] {
    GM_OFF   = 2'd0,
    GM_EDGE  = 2'd1,
    GM_LEVEL = 2'd2,
    GM_OFFB  = 2'd3
  } gateMode_e;

  typedef struct packed {
    logic pop;   // retire the FIFO head
    logic load;  // copy the FIFO head into the output slot
  } gateStrobe_t;
endpackage

// File: rtl/tgDatapath.sv
module tgDatapath
  import tgate_pkg::*;
#(
  parameter int CH_W  = 4,
  parameter int TS_W  = 32,
  parameter int DEPTH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [CH_W-1:0]   inChan,
  input  logic [TS_W-1:0]   inTs,
  input  logic              inLevel,
  output logic              inReady,
  input  gateStrobe_t       strb,
  output logic              headValid,
  output logic [CH_W-1:0]   headChan,
  output logic [TS_W-1:0]   headTs,
  output logic              headLvl,
  output logic              slotFree,
  output logic              outValid,
  input  logic              outReady,
  output logic [CH_W-1:0]   outChan,
  output logic [TS_W-1:0]   outTs
);
  localparam int PTR_W = (DEPTH > 2) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [CH_W-1:0]  chanMem [DEPTH];
  logic [TS_W-1:0]  tsMem   [DEPTH];
  logic [DEPTH-1:0] lvlMem;
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic             push;

  assign inReady   = (count != CNT_W'(DEPTH));
  assign push      = inValid && inReady;
  assign headValid = (count != '0);
  assign headChan  = chanMem[rdPtr];
  assign headTs    = tsMem[rdPtr];
  assign headLvl   = lvlMem[rdPtr];
  assign slotFree  = !outValid || outReady;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) begin
      chanMem[wrPtr] <= inChan;
      tsMem[wrPtr]   <= inTs;
      lvlMem[wrPtr]  <= inLevel;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push)     wrPtr <= nextPtr(wrPtr);
      if (strb.pop) rdPtr <= nextPtr(rdPtr);
      count <= count + CNT_W'(push) - CNT_W'(strb.pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outChan  <= '0;
      outTs    <= '0;
    end else if (strb.load) begin
      outValid <= 1'b1;
      outChan  <= headChan;
      outTs    <= headTs;
    end else if (outReady) begin
      outValid <= 1'b0;
    end
  end

  // R10: the control never retires from an empty FIFO
  a_r10_pop_not_empty: assert property (@(posedge clk) disable iff (!rstN)
    strb.pop |-> (count != '0));
  // R10: the control loads only into a free output slot
  a_r10_load_slot_free: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |-> slotFree);
  // R10: a stalled output tag stays put
  a_r10_out_stable: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outTs) && $stable(outChan)));
endmodule

// File: rtl/tgGateCtrl.sv
module tgGateCtrl
  import tgate_pkg::*;
#(
  parameter int CH_W    = 4,
  parameter int TS_W    = 32,
  parameter int OFF_W   = 8,
  parameter int WID_W   = 16,
  parameter int TRIG_CH = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              inReady,
  input  logic [CH_W-1:0]   inChan,
  input  logic [TS_W-1:0]   inTs,
  input  logic [TS_W-1:0]   nowTime,
  input  logic [1:0]        mode,
  input  logic [OFF_W-1:0]  gateOffset,
  input  logic [WID_W-1:0]  gateWidth,
  input  logic              passTrig,
  input  logic              headValid,
  input  logic [CH_W-1:0]   headChan,
  input  logic [TS_W-1:0]   headTs,
  input  logic              headLvl,
  input  logic              slotFree,
  output gateStrobe_t       strb
);
  localparam int HOLD  = 2 ** (OFF_W - 1);
  localparam int EXT_W = TS_W + 2;

  logic                    pendValid, gateValid;
  logic signed [EXT_W-1:0] pendStart, gateStart;
  logic signed [EXT_W-1:0] trigStart, headExt, curStart, winEnd;
  logic                    trigFire, releaseOk, promote, curValid, inWin, isTrig, pass;

  assign trigFire  = inValid && inReady && (inChan == CH_W'(TRIG_CH));
  assign trigStart = $signed({2'b00, inTs})
                   + $signed({{(EXT_W-OFF_W){gateOffset[OFF_W-1]}}, gateOffset});
  assign headExt   = $signed({2'b00, headTs});
  assign releaseOk = headValid && slotFree
                   && ({1'b0, nowTime} >= ({1'b0, headTs} + (TS_W+1)'(HOLD)));
  assign promote   = pendValid && (pendStart <= headExt);
  assign curValid  = promote || gateValid;
  assign curStart  = promote ? pendStart : gateStart;
  assign winEnd    = curStart + $signed({{(EXT_W-WID_W){1'b0}}, gateWidth});
  assign inWin     = curValid && (headExt >= curStart) && (headExt < winEnd);
  assign isTrig    = (headChan == CH_W'(TRIG_CH));

  always_comb begin
    case (mode)
      GM_EDGE:  pass = isTrig ? passTrig : inWin;
      GM_LEVEL: pass = headLvl;
      default:  pass = 1'b1;
    endcase
    strb.pop  = releaseOk;
    strb.load = releaseOk && pass;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendStart <= '0;
      gateValid <= 1'b0;
      gateStart <= '0;
    end else begin
      if (releaseOk && promote) begin
        gateValid <= 1'b1;
        gateStart <= pendStart;
        pendValid <= 1'b0;
      end
      if (trigFire) begin
        pendValid <= 1'b1;
        pendStart <= trigStart;
      end
    end
  end

  // R4: once a window exists it is only ever replaced, never lost
  a_r4_gate_kept: assert property (@(posedge clk) disable iff (!rstN)
    gateValid |=> gateValid);
  // R6: an accepted trigger is always waiting to be applied on the next cycle
  a_r6_trig_pending: assert property (@(posedge clk) disable iff (!rstN)
    trigFire |=> pendValid);
endmodule

// File: rtl/tagGate.sv
module tagGate
  import tgate_pkg::*;
#(
  parameter int CH_W    = 4,
  parameter int TS_W    = 32,
  parameter int DEPTH   = 8,
  parameter int OFF_W   = 8,
  parameter int WID_W   = 16,
  parameter int TRIG_CH = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TS_W-1:0]   nowTime,
  input  logic [1:0]        gateMode,
  input  logic [OFF_W-1:0]  gateOffset,
  input  logic [WID_W-1:0]  gateWidth,
  input  logic              passTrig,
  input  logic              levelIn,
  input  logic              inValid,
  output logic              inReady,
  input  logic [CH_W-1:0]   inChan,
  input  logic [TS_W-1:0]   inTs,
  output logic              outValid,
  input  logic              outReady,
  output logic [CH_W-1:0]   outChan,
  output logic [TS_W-1:0]   outTs
);
  localparam int HOLD = 2 ** (OFF_W - 1);

  gateStrobe_t      strb;
  logic             headValid, headLvl, slotFree;
  logic [CH_W-1:0]  headChan;
  logic [TS_W-1:0]  headTs;

  tgDatapath #(.CH_W(CH_W), .TS_W(TS_W), .DEPTH(DEPTH)) uData (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inChan(inChan), .inTs(inTs),
    .inLevel(levelIn), .inReady(inReady), .strb(strb), .headValid(headValid),
    .headChan(headChan), .headTs(headTs), .headLvl(headLvl), .slotFree(slotFree),
    .outValid(outValid), .outReady(outReady), .outChan(outChan), .outTs(outTs)
  );

  tgGateCtrl #(.CH_W(CH_W), .TS_W(TS_W), .OFF_W(OFF_W), .WID_W(WID_W),
               .TRIG_CH(TRIG_CH)) uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inChan(inChan),
    .inTs(inTs), .nowTime(nowTime), .mode(gateMode), .gateOffset(gateOffset),
    .gateWidth(gateWidth), .passTrig(passTrig), .headValid(headValid),
    .headChan(headChan), .headTs(headTs), .headLvl(headLvl), .slotFree(slotFree),
    .strb(strb)
  );

  // R2: no stored tag is retired before its hold time has passed
  a_r2_hold_respected: assert property (@(posedge clk) disable iff (!rstN)
    strb.pop |-> ({1'b0, nowTime} >= ({1'b0, headTs} + (TS_W+1)'(HOLD))));
  // R7: trigger tags stay blocked in edge mode unless enabled
  a_r7_trig_blocked: assert property (@(posedge clk) disable iff (!rstN)
    (gateMode == GM_EDGE && !passTrig && strb.load) |-> (headChan != CH_W'(TRIG_CH)));
  // R8: the level gate loads only tags sampled while the level was high
  a_r8_level_low_drop: assert property (@(posedge clk) disable iff (!rstN)
    (gateMode == GM_LEVEL && strb.load) |-> headLvl);
endmodule

// File: tb/sim_tagGate.sv
module sim_tagGate;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] nowTime = '0;
  logic [1:0]  gateMode = '0;
  logic [7:0]  gateOffset = '0;
  logic [15:0] gateWidth = '0;
  logic        passTrig = 1'b0;
  logic        levelIn = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [3:0]  inChan = '0;
  logic [31:0] inTs = '0;
  logic        outValid;
  logic        outReady = 1'b1;
  logic [3:0]  outChan;
  logic [31:0] outTs;

  int testsRun = 0;
  int testsFail = 0;
  int recCnt;
  logic [3:0]  recChan [64];
  logic [31:0] recTs   [64];

  always #2.5 clk = ~clk;

  tagGate u0 (.*);

  typedef struct packed {
    logic [1:0]  mode;
    logic [7:0]  off;
    logic [15:0] wid;
    logic [31:0] tagTs;
    logic        lvl;
    logic        exp;
  } vec_t;

  // trigger always at 1000 on channel 7, data tag on channel 1
  localparam vec_t VECS [12] = '{
    '{2'd1, 8'd0,    16'd50, 32'd1020, 1'b0, 1'b1},
    '{2'd1, 8'd0,    16'd50, 32'd1050, 1'b0, 1'b0},
    '{2'd1, 8'd0,    16'd50, 32'd1049, 1'b0, 1'b1},
    '{2'd1, 8'h9C,   16'd50, 32'd920,  1'b0, 1'b1},
    '{2'd1, 8'h9C,   16'd50, 32'd960,  1'b0, 1'b0},
    '{2'd1, 8'd20,   16'd10, 32'd1019, 1'b0, 1'b0},
    '{2'd1, 8'd20,   16'd10, 32'd1020, 1'b0, 1'b1},
    '{2'd1, 8'd0,    16'd50, 32'd990,  1'b0, 1'b0},
    '{2'd0, 8'd0,    16'd0,  32'd5,    1'b0, 1'b1},
    '{2'd2, 8'd0,    16'd0,  32'd5,    1'b1, 1'b1},
    '{2'd2, 8'd0,    16'd0,  32'd5,    1'b0, 1'b0},
    '{2'd3, 8'd0,    16'd0,  32'd5,    1'b0, 1'b1}
  };

  always @(negedge clk) begin
    if (!rstN) recCnt = 0;
    else if (outValid && outReady && recCnt < 64) begin
      recChan[recCnt] = outChan;
      recTs[recCnt]   = outTs;
      recCnt = recCnt + 1;
    end
  end

  task automatic check(input logic ok, input string req, input longint act, input longint expv);
    testsRun++;
    if (!ok) begin
      testsFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic logic seen(input logic [3:0] ch, input logic [31:0] ts);
    for (int i = 0; i < recCnt; i++)
      if (recChan[i] == ch && recTs[i] == ts) return 1'b1;
    return 1'b0;
  endfunction

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; nowTime = '0; inValid = 1'b0; outReady = 1'b1;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic push(input logic [3:0] ch, input logic [31:0] ts, input logic lvl);
    @(negedge clk);
    inValid = 1'b1; inChan = ch; inTs = ts; levelIn = lvl;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic releaseAll();
    @(negedge clk);
    nowTime = 32'd100000;
    repeat (12) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    testsFail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFail);
    $finish;
  end

  initial begin
    doReset();
    @(negedge clk);
    check(outValid == 1'b0, "R1 outValid", outValid, 0);
    check(inReady == 1'b1, "R1 inReady", inReady, 1);

    for (int v = 0; v < 12; v++) begin
      string req;
      doReset();
      gateMode = VECS[v].mode; gateOffset = VECS[v].off;
      gateWidth = VECS[v].wid; passTrig = 1'b0;
      if (VECS[v].tagTs < 32'd1000) begin
        push(4'd1, VECS[v].tagTs, VECS[v].lvl);
        push(4'd7, 32'd1000, VECS[v].lvl);
      end else begin
        push(4'd7, 32'd1000, VECS[v].lvl);
        push(4'd1, VECS[v].tagTs, VECS[v].lvl);
      end
      releaseAll();
      if (VECS[v].mode == 2'd1) req = VECS[v].off[7] ? "R5 edge neg offset" : "R4 edge window";
      else if (VECS[v].mode == 2'd2) req = "R8 level gate";
      else req = "R3 off mode";
      check(seen(4'd1, VECS[v].tagTs) == VECS[v].exp, req,
            seen(4'd1, VECS[v].tagTs), VECS[v].exp);
    end

    // R2: hold boundary and order
    doReset();
    gateMode = 2'd0;
    push(4'd2, 32'd500, 1'b0);
    push(4'd3, 32'd510, 1'b0);
    @(negedge clk); nowTime = 32'd627;
    repeat (5) @(negedge clk);
    check(recCnt == 0, "R2 held before ts+128", recCnt, 0);
    nowTime = 32'd628;
    repeat (3) @(negedge clk);
    check(recCnt == 1, "R2 released at ts+128", recCnt, 1);
    releaseAll();
    check(recCnt == 2 && recTs[0] == 500 && recTs[1] == 510, "R2 order", recTs[1], 510);

    // R6: retrigger restarts the window
    doReset();
    gateMode = 2'd1; gateOffset = 8'd0; gateWidth = 16'd50;
    push(4'd7, 32'd1000, 1'b0);
    push(4'd7, 32'd1030, 1'b0);
    push(4'd1, 32'd1060, 1'b0);
    releaseAll();
    check(seen(4'd1, 32'd1060), "R6 retrigger window", seen(4'd1, 32'd1060), 1);

    // R7: trigger tag forwarding
    for (int p = 0; p < 2; p++) begin
      doReset();
      gateMode = 2'd1; gateOffset = 8'd0; gateWidth = 16'd50; passTrig = p[0];
      push(4'd7, 32'd1000, 1'b0);
      push(4'd1, 32'd1010, 1'b0);
      releaseAll();
      check(seen(4'd7, 32'd1000) == p[0], "R7 trigger pass bit", seen(4'd7, 32'd1000), p);
    end

    // R9: mode applied at release
    doReset();
    gateMode = 2'd2;
    push(4'd1, 32'd40, 1'b0);
    @(negedge clk); gateMode = 2'd0;
    releaseAll();
    check(seen(4'd1, 32'd40), "R9 level->off passes", seen(4'd1, 32'd40), 1);
    doReset();
    gateMode = 2'd0;
    push(4'd1, 32'd41, 1'b0);
    @(negedge clk); gateMode = 2'd2;
    releaseAll();
    check(!seen(4'd1, 32'd41), "R9 off->level drops", seen(4'd1, 32'd41), 0);

    // R10: backpressure holds output
    doReset();
    gateMode = 2'd0;
    outReady = 1'b0;
    push(4'd2, 32'd500, 1'b0);
    push(4'd2, 32'd501, 1'b0);
    releaseAll();
    check(outValid == 1'b1 && outTs == 500, "R10 stalled output", outTs, 500);
    repeat (3) @(negedge clk);
    check(outValid == 1'b1 && outTs == 500, "R10 output stable", outTs, 500);
    outReady = 1'b1;
    repeat (6) @(negedge clk);
    check(recCnt == 2 && recTs[1] == 501, "R10 drain after stall", recCnt, 2);

    // R10: full FIFO refuses input
    doReset();
    gateMode = 2'd0;
    for (int k = 0; k < 8; k++) push(4'd2, 32'(600 + k), 1'b0);
    @(negedge clk);
    check(inReady == 1'b0, "R10 full inReady", inReady, 0);
    push(4'd2, 32'd900, 1'b0);
    releaseAll();
    check(recCnt == 8 && !seen(4'd2, 32'd900), "R10 full drop", recCnt, 8);

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFail);
    $finish;
  end
endmodule